// File: doc/BRIEF.md
# Parallel Port Host Interface and Configuration Decoder

This block is the host-facing front end of a 24-line parallel I/O controller. It has three 8-bit ports, A, B and C. Port C is split into an upper nibble and a lower nibble. The host reaches the block through an active-low chip select, an active-low data strobe, a read/not-write select and a two-bit address. The block decodes these into reads and writes of the three port latches and of a control byte that can only be written.

All host inputs are asynchronous. They pass through a two-flop synchronizer and a third alignment stage, and every decision is made on the system clock. The control byte has two forms, chosen by bit 7:
- A mode word sets the direction and operating mode of both port groups. It also wipes all output state and pulses a load strobe so the handshake blocks can clear their status.
- A bit set/reset word changes a single port C bit.

When a group's handshake mode claims some port C positions, those positions are protected. They are left out of plain port C writes, and a set/reset aimed at an interrupt-enable position is routed to that enable flag.

The outputs are the per-port and per-nibble drive enables, the group mode codes, the port latches, the mask of port C positions reserved for handshake, and the three interrupt-enable flags. The handshake sequencing for the strobed and bidirectional modes is built elsewhere and uses these outputs.

Top module: `ppi_ctrl_decoder`

## Requirements
- R1: While `rst` is high, and after it falls until the first write, all four drive enables are 0. Both group modes are 0. All latches, enables, `cfg_load` and `dout_en` are 0. Every direction is input.
- R2: A host write is taken when `ds_n` rises while `cs_n` and `rnw` are low. Address 00 loads `pa_out` and address 01 loads `pb_out`. The values used are those sampled one clock before the strobe rise. The result is visible after the second clock edge that follows the first clock edge sampling the strobe high.
- R3: While `cs_n` is high, no strobe changes any latch or configuration, and `dout_en` stays 0.
- R4: `dout_en` is 1 only while the synchronized `cs_n` is low, `ds_n` is low and `rnw` is high, and the address is not 11. At all other times `dout_en` is 0 and `dout` is 0.
- R5: A read of port A or port B returns the latch when that port is an output and the pins when it is an input. A read of port C returns, per bit, the pin for reserved positions and for input nibbles, and the latch otherwise.
- R6: A write to address 11 with bit 7 set is a mode word. Bit 4 sets the direction of port A, bit 3 of port C upper, bit 1 of port B and bit 0 of port C lower. A 1 means input, so the matching enable is 0.
- R7: In a mode word, bits 6..5 give the group A mode: 00 is mode 0, 01 is mode 1 and 1x is mode 2, reported as `grpa_mode` 0, 1 or 2. Bit 2 gives the group B mode on `grpb_mode`. In group A mode 2, `pa_oe` and `pcu_oe` are 0.
- R8: A mode word clears `pa_out`, `pb_out`, `pc_out` and all three interrupt enables. It raises `cfg_load` for exactly one cycle.
- R9: A write to address 11 with bit 7 clear is a set/reset. Bits 3..1 select the port C bit and bit 0 is the new value. On an unreserved position, only that bit of `pc_out` changes.
- R10: `pc_hs_mask` marks the reserved port C positions:
  - group A mode 1 with port A as input: bits 3, 4 and 5;
  - group A mode 1 with port A as output: bits 3, 6 and 7;
  - group A mode 2: bits 3 to 7;
  - group B mode 1: bits 0 to 2.
  A port C data write leaves reserved bits of `pc_out` unchanged.
- R11: A set/reset aimed at a reserved position leaves `pc_out` unchanged. Three positions are routed to an enable flag instead:
  - bit 4 sets `ien_a_in` when group A is in mode 1 input or mode 2;
  - bit 6 sets `ien_a_out` when group A is in mode 1 output or mode 2;
  - bit 2 sets `ien_b` when group B is in mode 1.
  Other reserved positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rnw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Target: 00 A, 01 B, 10 C, 11 control |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_en | output | 1 | Host bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin and handshake status values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_oe | output | 1 | Port B drive enable |
| pcu_oe | output | 1 | Port C bits 7..4 drive enable |
| pcl_oe | output | 1 | Port C bits 3..0 drive enable |
| grpa_mode | output | 2 | Group A mode code 0, 1 or 2 |
| grpb_mode | output | 1 | Group B mode code 0 or 1 |
| pc_hs_mask | output | 8 | Port C positions reserved for handshake |
| ien_a_in | output | 1 | Group A input interrupt enable |
| ien_a_out | output | 1 | Group A output interrupt enable |
| ien_b | output | 1 | Group B interrupt enable |
| cfg_load | output | 1 | One-cycle pulse on each mode word |

## Verification
A corrupted direction or mode register shows up at once on the enables, the mode codes and `pc_hs_mask`, all of which are compared every clock. A wrong synchronizer stage or edge detector moves a latch update or `dout_en` by at least one cycle, and the per-clock comparison catches that at the edge where the update lands. Wrong reserved-position steering stays hidden until a port C write or set/reset touches a protected bit. The bench therefore drives such writes in every handshake mode and reads port C back through the host bus.

// File: rtl/ppi_ctrl_decoder.sv
module ppi_ctrl_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       ds_n,
  input  logic       rnw,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pc_out,
  output logic       pa_oe,
  output logic       pb_oe,
  output logic       pcu_oe,
  output logic       pcl_oe,
  output logic [1:0] grpa_mode,
  output logic       grpb_mode,
  output logic [7:0] pc_hs_mask,
  output logic       ien_a_in,
  output logic       ien_a_out,
  output logic       ien_b,
  output logic       cfg_load
);

  // bus snapshot: {cs_n, ds_n, rnw, addr, din}
  localparam logic [12:0] IDLE = 13'h1800;

  logic [12:0] s1, s2, s3;
  logic        dir_a, dir_cu, dir_b, dir_cl;
  logic [1:0]  amode;
  logic        bmode;
  logic [7:0]  resv, pc_view, rd_sel;
  logic [1:0]  wa;
  logic [7:0]  wd;
  logic [2:0]  bidx;
  logic        wr_stb, a_in_pos, a_out_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= {cs_n, ds_n, rnw, addr, din};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign wr_stb = s2[11] & ~s3[11] & ~s3[12] & ~s3[10];
  assign wa     = s3[9:8];
  assign wd     = s3[7:0];
  assign bidx   = wd[3:1];

  always_comb begin
    resv = 8'h00;
    unique case (amode)
      2'd1:    resv[7:3] = dir_a ? 5'b00111 : 5'b11001;
      2'd2:    resv[7:3] = 5'b11111;
      default: resv[7:3] = 5'b00000;
    endcase
    if (bmode) resv[2:0] = 3'b111;
  end

  assign a_in_pos  = (amode == 2'd2) | ((amode == 2'd1) & dir_a);
  assign a_out_pos = (amode == 2'd2) | ((amode == 2'd1) & ~dir_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_out    <= 8'h00;
      pb_out    <= 8'h00;
      pc_out    <= 8'h00;
      dir_a     <= 1'b1;
      dir_cu    <= 1'b1;
      dir_b     <= 1'b1;
      dir_cl    <= 1'b1;
      amode     <= 2'd0;
      bmode     <= 1'b0;
      ien_a_in  <= 1'b0;
      ien_a_out <= 1'b0;
      ien_b     <= 1'b0;
      cfg_load  <= 1'b0;
    end else begin
      cfg_load <= 1'b0;
      if (wr_stb) begin
        unique case (wa)
          2'd0: pa_out <= wd;
          2'd1: pb_out <= wd;
          2'd2: pc_out <= (pc_out & resv) | (wd & ~resv);
          default: begin
            if (wd[7]) begin
              amode     <= wd[6] ? 2'd2 : {1'b0, wd[5]};
              dir_a     <= wd[4];
              dir_cu    <= wd[3];
              bmode     <= wd[2];
              dir_b     <= wd[1];
              dir_cl    <= wd[0];
              pa_out    <= 8'h00;
              pb_out    <= 8'h00;
              pc_out    <= 8'h00;
              ien_a_in  <= 1'b0;
              ien_a_out <= 1'b0;
              ien_b     <= 1'b0;
              cfg_load  <= 1'b1;
            end else if (!resv[bidx]) begin
              pc_out[bidx] <= wd[0];
            end else begin
              if (bidx == 3'd4 && a_in_pos)  ien_a_in  <= wd[0];
              if (bidx == 3'd6 && a_out_pos) ien_a_out <= wd[0];
              if (bidx == 3'd2 && bmode)     ien_b     <= wd[0];
            end
          end
        endcase
      end
    end
  end

  assign pa_oe      = ~dir_a & (amode != 2'd2);
  assign pb_oe      = ~dir_b;
  assign pcu_oe     = ~dir_cu & (amode != 2'd2);
  assign pcl_oe     = ~dir_cl;
  assign grpa_mode  = amode;
  assign grpb_mode  = bmode;
  assign pc_hs_mask = resv;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (resv[i])      pc_view[i] = pc_in[i];
      else if (i >= 4)  pc_view[i] = pcu_oe ? pc_out[i] : pc_in[i];
      else              pc_view[i] = pcl_oe ? pc_out[i] : pc_in[i];
    end
  end

  always_comb begin
    unique case (s2[9:8])
      2'd0:    rd_sel = pa_oe ? pa_out : pa_in;
      2'd1:    rd_sel = pb_oe ? pb_out : pb_in;
      2'd2:    rd_sel = pc_view;
      default: rd_sel = 8'h00;
    endcase
  end

  assign dout_en = ~s2[12] & ~s2[11] & s2[10] & (s2[9:8] != 2'b11);
  assign dout    = dout_en ? rd_sel : 8'h00;

endmodule

module ppi_ctrl_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_stb,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic       pa_oe,
  input logic       pb_oe,
  input logic       pcu_oe,
  input logic       pcl_oe,
  input logic [1:0] grpa_mode,
  input logic       grpb_mode,
  input logic [7:0] pc_hs_mask,
  input logic       ien_a_in,
  input logic       ien_a_out,
  input logic       ien_b,
  input logic       cfg_load
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!pa_oe && !pb_oe && !pcu_oe && !pcl_oe && grpa_mode == 2'd0 && !grpb_mode && !cfg_load));

  p_latch_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pa_out) |-> $past(wr_stb));

  p_mode2_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (grpa_mode == 2'd2) |-> (!pa_oe && !pcu_oe));

  p_mode_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
    grpa_mode != 2'd3);

  p_cfg_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !cfg_load);

  p_cfg_clears_state_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00 && !ien_a_in && !ien_a_out && !ien_b));

  p_mask_mode0_r10: assert property (@(posedge clk) disable iff (rst)
    (grpa_mode == 2'd0 && !grpb_mode) |-> (pc_hs_mask == 8'h00));

  p_ienb_needs_mode_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(ien_b) |-> grpb_mode);

endmodule

bind ppi_ctrl_decoder ppi_ctrl_decoder_chk u_chk (.*);

// File: tb/ppi_ctrl_decoder_test.sv
`timescale 1ns/100ps
module ppi_ctrl_decoder_test;

  localparam logic [12:0] IDLE = 13'h1800;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00, pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] dout, pa_out, pb_out, pc_out, pc_hs_mask;
  logic       dout_en, pa_oe, pb_oe, pcu_oe, pcl_oe, grpb_mode;
  logic [1:0] grpa_mode;
  logic       ien_a_in, ien_a_out, ien_b, cfg_load;

  int nchk = 0, nfail = 0;
  bit done = 0, seen_edge = 0;

  always #2.5 clk = ~clk;

  ppi_ctrl_decoder uut (.*);

  // reference model state
  logic [12:0] hq[$];
  logic [7:0]  m_pa, m_pb, m_pc;
  logic        m_da, m_dcu, m_db, m_dcl, m_bm, m_ia, m_io, m_ib, m_cfg;
  int          m_am;

  function automatic logic [7:0] m_resv();
    logic [7:0] r = 8'h00;
    if (m_am == 1 && m_da)  r = r | 8'h38;
    if (m_am == 1 && !m_da) r = r | 8'hC8;
    if (m_am == 2)          r = r | 8'hF8;
    if (m_bm)               r = r | 8'h07;
    return r;
  endfunction

  task automatic m_apply(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] r = m_resv();
    int k = d[3:1];
    if (a == 0) m_pa = d;
    else if (a == 1) m_pb = d;
    else if (a == 2) begin
      for (int i = 0; i < 8; i++) if (!r[i]) m_pc[i] = d[i];
    end else if (d[7]) begin
      m_am = d[6] ? 2 : (d[5] ? 1 : 0);
      m_da = d[4]; m_dcu = d[3]; m_bm = d[2]; m_db = d[1]; m_dcl = d[0];
      m_pa = 0; m_pb = 0; m_pc = 0; m_ia = 0; m_io = 0; m_ib = 0; m_cfg = 1;
    end else if (!r[k]) m_pc[k] = d[0];
    else begin
      if (k == 4 && (m_am == 2 || (m_am == 1 && m_da)))  m_ia = d[0];
      if (k == 6 && (m_am == 2 || (m_am == 1 && !m_da))) m_io = d[0];
      if (k == 2 && m_bm) m_ib = d[0];
    end
  endtask

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      m_pa = 0; m_pb = 0; m_pc = 0; m_am = 0; m_bm = 0;
      m_da = 1; m_dcu = 1; m_db = 1; m_dcl = 1;
      m_ia = 0; m_io = 0; m_ib = 0; m_cfg = 0;
      hq = '{IDLE, IDLE, IDLE};
    end else begin
      m_cfg = 0;
      if (hq[1][11] && !hq[2][11] && !hq[2][12] && !hq[2][10])
        m_apply(hq[2][9:8], hq[2][7:0]);
      hq.push_front({cs_n, ds_n, rnw, addr, din});
      void'(hq.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read();
    logic [7:0] r = m_resv();
    logic [7:0] v;
    logic       ao = !m_da && m_am != 2, bo = !m_db, uo = !m_dcu && m_am != 2, lo = !m_dcl;
    for (int i = 0; i < 8; i++)
      v[i] = r[i] ? pc_in[i] : (((i >= 4) ? uo : lo) ? m_pc[i] : pc_in[i]);
    case (hq[1][9:8])
      2'd0: return ao ? m_pa : pa_in;
      2'd1: return bo ? m_pb : pb_in;
      2'd2: return v;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (seen_edge && rst) begin
      chk("R1 enables", {pa_oe, pb_oe, pcu_oe, pcl_oe}, 0);
      chk("R1 modes", {grpa_mode, grpb_mode}, 0);
      chk("R1 latches", {pa_out, pb_out, pc_out}, 0);
      chk("R1 flags", {ien_a_in, ien_a_out, ien_b, cfg_load, dout_en}, 0);
    end else if (seen_edge) begin
      logic en_e;
      en_e = !hq[1][12] && !hq[1][11] && hq[1][10] && hq[1][9:8] != 2'b11;
      chk("R2 pa_out", pa_out, m_pa);
      chk("R2 pb_out", pb_out, m_pb);
      chk("R9 pc_out", pc_out, m_pc);
      chk("R6 enables", {pa_oe, pb_oe, pcu_oe, pcl_oe},
          {!m_da && m_am != 2, !m_db, !m_dcu && m_am != 2, !m_dcl});
      chk("R7 grpa_mode", grpa_mode, m_am[1:0]);
      chk("R7 grpb_mode", grpb_mode, m_bm);
      chk("R8 cfg_load", cfg_load, m_cfg);
      chk("R10 pc_hs_mask", pc_hs_mask, m_resv());
      chk("R11 enables", {ien_a_in, ien_a_out, ien_b}, {m_ia, m_io, m_ib});
      chk("R4 dout_en", dout_en, en_e);
      chk("R5 dout", dout, en_e ? m_read() : 8'h00);
    end
  end

  task automatic bus(input logic c, input logic r, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs_n = c; rnw = r; addr = a; din = d; ds_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 ds_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 cs_n = 1'b1; rnw = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(1'b0, 1'b0, a, d);
  endtask

  task automatic rd(input logic [1:0] a);
    bus(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    pa_in = 8'hC3; pb_in = 8'h3C; pc_in = 8'hA5;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    // R2/R5: port A latch written while input, read returns pins
    wr(2'd0, 8'h5A);
    rd(2'd0);
    // R6: all outputs mode 0
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'h33);
    rd(2'd0); rd(2'd1); rd(2'd2);
    // R3: chip select high blocks write and read
    bus(1'b1, 1'b0, 2'd0, 8'hEE);
    @(negedge clk); chk("R3 write blocked", pa_out, 8'h11);
    @(posedge clk); #1 cs_n = 1'b1; rnw = 1'b1; ds_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R3 no drive", dout_en, 1'b0);
    #1 ds_n = 1'b1;
    // R4: control read is illegal
    @(posedge clk); #1 cs_n = 1'b0; rnw = 1'b1; addr = 2'd3; ds_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R4 control read floats", dout_en, 1'b0);
    #1 ds_n = 1'b1; cs_n = 1'b1;
    // mixed directions, port C read
    wr(2'd3, 8'h91);
    wr(2'd2, 8'hF0);
    rd(2'd2); rd(2'd0);
    // R9: set/reset free bits
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h0F); wr(2'd3, 8'h05); wr(2'd3, 8'h0E);
    @(negedge clk); chk("R9 bit set/clear", pc_out, 8'h04);
    // group A mode 1 input, group B mode 1
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hB4);
    @(negedge clk); chk("R10 mask A1in B1", pc_hs_mask, 8'h3F);
    wr(2'd2, 8'hFF);
    @(negedge clk); chk("R10 protected write", pc_out, 8'hC0);
    wr(2'd3, 8'h09); wr(2'd3, 8'h05); wr(2'd3, 8'h0B);
    @(negedge clk); chk("R11 steer", {ien_a_in, ien_a_out, ien_b, pc_out}, {3'b101, 8'hC0});
    rd(2'd2);
    // group A mode 1 output
    wr(2'd3, 8'hA0);
    @(negedge clk); chk("R8 cleared", {ien_a_in, ien_b, pc_out}, 0);
    wr(2'd3, 8'h0D); wr(2'd3, 8'h09); wr(2'd3, 8'h0F);
    @(negedge clk); chk("R11 out enable", {ien_a_out, ien_a_in, pc_out}, {2'b10, 8'h10});
    // mode 2 via 10 and 11 codes
    wr(2'd3, 8'hC0);
    wr(2'd3, 8'h09); wr(2'd3, 8'h0D); wr(2'd3, 8'h0B);
    @(negedge clk); chk("R7 mode2", {grpa_mode, pa_oe, pcu_oe}, {2'd2, 2'b00});
    wr(2'd3, 8'hE2);
    rd(2'd0); rd(2'd1); rd(2'd2);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom);
      d = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if (a == 2'd3 && d[7] && ($urandom % 3 != 0)) d[7] = 1'b0;
      bus(($urandom % 8) == 0, ($urandom % 3) == 0, a, d);
    end
    repeat (5) @(posedge clk);
    done = 1;
    finish_up();
  end

endmodule